// File: doc/BRIEF.md
# Strobed Serial Configuration and Diagnostic Port

This block is the serial slave port of a motor driver controller. A master frames each transfer by pulling an active-low strobe, then clocks a 16-bit word into the port most significant bit first on rising edges of the serial clock. When the strobe returns high after exactly sixteen rising edges, the top bits of the received word select one of four configuration targets. The block then issues a one-cycle write strobe for that target together with the remaining data bits. Frames with any other edge count are dropped and recorded as a framing error.

During the same frame, the port returns a diagnostic word on its data output. The top bit of that word is a fault summary flag. It is placed on the output as soon as the strobe goes low, so a master can poll fault state with the strobe alone. The other bits shift out after the falling clock edges. Two fault registers latch pulses from the fault inputs. A completed read reloads them from the inputs, so only conditions that are still present survive the read.

All serial pins are treated as already synchronous to the block clock. Edges of the serial clock and the strobe are detected by comparing each pin with its value from the previous cycle.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, the data output enable is low, the data output is low and no write strobe is active.
- R2: While the strobe is high, the data output enable is 0 and the data output is 0. Serial clock and data activity in that state causes no write.
- R3: When the strobe falls, the data output shows the fault summary flag in the same cycle, before any serial clock edge.
- R4: The diagnostic word is sent MSB first. Bit 15 is the summary flag and bit 14 is the framing error. Bits 13:7 are fault register 0 and bits 6:0 are fault register 1. The data output advances one bit after each falling clock edge that follows the first rising edge of the frame.
- R5: The data input is sampled on rising serial clock edges, MSB first. When the strobe rises after exactly 16 rising edges, the port does two things. It drives `wr_sel` one-hot for one clock cycle, with bit index equal to received bits 15:14. It presents received bits 13:0 on `wr_data`.
- R6: When the strobe rises after any edge count other than 16, nothing is written and the framing error bit is set.
- R7: A high level on any fault input bit sets the matching latched fault bit, and the latched bit stays set until a valid frame completes.
- R8: A valid frame reloads both fault registers from the current fault inputs, so still-active faults remain set. It also clears the framing error.
- R9: The summary flag is the OR of the framing error and all latched fault bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame strobe |
| sdo | output | 1 | Serial data out (0 while not driven) |
| sdo_oe | output | 1 | Output enable for the data out pad |
| wr_sel | output | 4 | One-hot write strobe per target register |
| wr_data | output | 14 | Data for the selected target |
| fault0_in | input | 7 | Live fault conditions, group 0 |
| fault1_in | input | 7 | Live fault conditions, group 1 |

## Verification
The bench builds the port with its default 16-bit word and a 2-bit target field. This gives four write targets and two 7-bit fault groups, so every diagnostic bit position and every target index can be reached with directed frames. Short and long frames (15 and 17 edges) exercise the framing error path and its effect on the summary flag. A fault held active across a read shows that the reload after a read keeps live conditions while dropping pulsed ones.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sck,
  input  logic                                sdi,
  input  logic                                cs_n,
  output logic                                sdo,
  output logic                                sdo_oe,
  output logic [(1<<ADDR_W)-1:0]              wr_sel,
  output logic [WORD_W-ADDR_W-1:0]            wr_data,
  input  logic [(WORD_W-2)/2-1:0]             fault0_in,
  input  logic [(WORD_W-2)/2-1:0]             fault1_in
);
  localparam int FW = (WORD_W - 2) / 2;
  localparam int CW = $clog2(WORD_W + 2);
  localparam int NSEL = 1 << ADDR_W;

  logic          sck_q, cs_q, frame_err;
  logic [CW-1:0] cnt;
  logic [WORD_W-1:0] rx, tx;
  logic [FW-1:0] lat0, lat1;

  wire cs_fall  = cs_q & ~cs_n;
  wire cs_rise  = ~cs_q & cs_n;
  wire sck_rise = ~cs_n & sck & ~sck_q;
  wire sck_fall = ~cs_n & ~sck & sck_q;
  wire summary  = frame_err | (|lat0) | (|lat1);
  wire frame_ok = cs_rise && (cnt == CW'(WORD_W));

  assign sdo_oe = ~cs_n;
  assign sdo    = cs_n ? 1'b0 : (cs_q ? summary : tx[WORD_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b1;
      cs_q      <= 1'b1;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '0;
      lat0      <= '0;
      lat1      <= '0;
      frame_err <= 1'b0;
      wr_sel    <= '0;
      wr_data   <= '0;
    end else begin
      sck_q  <= sck;
      cs_q   <= cs_n;
      wr_sel <= '0;
      if (cs_fall) begin
        cnt <= '0;
        tx  <= {summary, frame_err, lat0, lat1};
      end else begin
        if (sck_rise) begin
          rx <= {rx[WORD_W-2:0], sdi};
          if (cnt != CW'(WORD_W + 1)) cnt <= cnt + 1'b1;
        end
        if (sck_fall && cnt != '0) tx <= {tx[WORD_W-2:0], 1'b0};
      end
      if (frame_ok) begin
        wr_sel    <= NSEL'(1) << rx[WORD_W-1 -: ADDR_W];
        wr_data   <= rx[WORD_W-ADDR_W-1:0];
        frame_err <= 1'b0;
        lat0      <= fault0_in;
        lat1      <= fault1_in;
      end else begin
        lat0 <= lat0 | fault0_in;
        lat1 <= lat1 | fault1_in;
        if (cs_rise) frame_err <= 1'b1;
      end
    end
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R5
  AST_WR_NEEDS_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_sel) |-> ($past(cnt) == CW'(WORD_W))); // R5
  AST_ERR_ON_BAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> ($past(cnt) != CW'(WORD_W))); // R6
  AST_LATCH0_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_sel) |-> ((lat0 & $past(lat0)) == $past(lat0))); // R7
  AST_LATCH1_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_sel) |-> ((lat1 & $past(lat1)) == $past(lat1))); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WORD_W + 1)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sdo && !sdo_oe)); // R2
endmodule

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b1, sdi = 1'b0, cs_n = 1'b1;
  logic sdo, sdo_oe;
  logic [3:0]  wr_sel;
  logic [13:0] wr_data;
  logic [6:0]  fault0_in = '0, fault1_in = '0;

  int n_tests = 0, n_fail = 0;
  logic        got_flag;
  logic [15:0] got_rd;
  logic [3:0]  got_sel, sel_next;
  logic [13:0] got_data;

  serial_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_n(cs_n),
    .sdo(sdo), .sdo_oe(sdo_oe), .wr_sel(wr_sel), .wr_data(wr_data),
    .fault0_in(fault0_in), .fault1_in(fault1_in));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] w, input int edges);
    got_rd = '0;
    cs_n = 1'b0;
    #1 got_flag = sdo;
    tick(2);
    for (int i = 0; i < edges; i++) begin
      sck = 1'b0;
      sdi = (i < 16) ? w[15-i] : 1'b0;
      tick(2);
      if (i < 16) got_rd[15-i] = sdo;
      sck = 1'b1;
      tick(2);
    end
    cs_n = 1'b1;
    tick(1);
    got_sel = wr_sel;
    got_data = wr_data;
    tick(1);
    sel_next = wr_sel;
    tick(2);
  endtask

  task automatic t_reset();
    check(sdo_oe == 1'b0, "R1 oe", sdo_oe, 0);
    check(sdo == 1'b0, "R1 sdo", sdo, 0);
    check(wr_sel == '0, "R1 wr_sel", wr_sel, 0);
  endtask

  task automatic t_idle();
    logic bad = 1'b0;
    for (int i = 0; i < 20; i++) begin
      sck = ~sck;
      sdi = i[1];
      tick(1);
      if (sdo_oe || sdo || (wr_sel != '0)) bad = 1'b1;
    end
    sck = 1'b1;
    tick(3);
    if (wr_sel != '0) bad = 1'b1;
    check(!bad, "R2 idle activity", bad, 0);
  endtask

  task automatic t_writes();
    xfer({2'b10, 14'h1A5C}, 16);
    check(got_flag == 1'b0, "R3 flag clear", got_flag, 0);
    check(got_rd == 16'h0000, "R4 clean word", got_rd, 0);
    check(got_sel == 4'b0100, "R5 sel addr2", got_sel, 4'b0100);
    check(got_data == 14'h1A5C, "R5 data addr2", got_data, 14'h1A5C);
    check(sel_next == '0, "R5 pulse width", sel_next, 0);
    xfer({2'b00, 14'h3FFF}, 16);
    check(got_sel == 4'b0001, "R5 sel addr0", got_sel, 1);
    check(got_data == 14'h3FFF, "R5 data addr0", got_data, 14'h3FFF);
    xfer({2'b11, 14'h0001}, 16);
    check(got_sel == 4'b1000, "R5 sel addr3", got_sel, 4'b1000);
    check(got_data == 14'h0001, "R5 data addr3", got_data, 1);
  endtask

  task automatic t_faults();
    fault0_in = 7'b0000101;
    fault1_in = 7'b0001000;
    tick(1);
    fault0_in = '0;
    tick(2);
    xfer({2'b01, 14'h0000}, 16);
    check(got_flag == 1'b1, "R3 R9 flag on fault", got_flag, 1);
    check(got_rd == {1'b1, 1'b0, 7'b0000101, 7'b0001000}, "R4 R7 fault word",
          got_rd, {1'b1, 1'b0, 7'b0000101, 7'b0001000});
    fault1_in = '0;
    tick(3);
    xfer({2'b01, 14'h0000}, 16);
    check(got_flag == 1'b1, "R8 active fault kept flag", got_flag, 1);
    check(got_rd == {2'b10, 7'b0, 7'b0001000}, "R8 active fault kept",
          got_rd, {2'b10, 7'b0, 7'b0001000});
    xfer({2'b01, 14'h0000}, 16);
    check(got_flag == 1'b0, "R8 cleared flag", got_flag, 0);
    check(got_rd == 16'h0000, "R8 cleared word", got_rd, 0);
  endtask

  task automatic t_framing();
    xfer({2'b10, 14'h0055}, 15);
    check(got_sel == '0, "R6 short no write", got_sel, 0);
    xfer({2'b00, 14'h0ABC}, 16);
    check(got_flag == 1'b1, "R6 R9 err flag", got_flag, 1);
    check(got_rd == 16'hC000, "R6 err word", got_rd, 16'hC000);
    check(got_sel == 4'b0001, "R5 write after err", got_sel, 1);
    xfer({2'b11, 14'h0123}, 17);
    check(got_sel == '0, "R6 long no write", got_sel, 0);
    xfer({2'b00, 14'h0000}, 16);
    check(got_rd == 16'hC000, "R6 long err word", got_rd, 16'hC000);
    xfer({2'b00, 14'h0000}, 16);
    check(got_rd == 16'h0000, "R8 err cleared", got_rd, 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_idle();
    t_writes();
    t_faults();
    t_framing();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule